// File: doc/BRIEF.md
# Super-Pixel Sparse Readout Link

This block is the shared readout logic of one group of eight pixels laid out as two columns by four rows. Each pixel reports a finished hit as a one-cycle strobe together with its data word. The block latches the word in a per-pixel holding slot. When at least one slot holds an unsent hit, it builds one packet. The packet carries the group address, a shared timestamp, an eight-bit hit mask and one data field per pixel. Only pixels with a hit fill their field, and all other fields are zero.

The packet goes up the column bus to an end-of-column unit over a two-phase handshake. Launching a packet inverts the request line. The receiver answers by inverting the acknowledge line once. While the packet is outstanding, the pixels keep detecting. A hit on an idle pixel during that time is held and goes out in the next packet. A pixel is released only after the acknowledge for the packet that carried it.

Top module: `sp_readout`

## Requirements
- R1: While rst_ni is low, req_o is 0 and every bit of pkt_o is 0.
- R2: Take a hit strobe on an idle pixel k, sampled at clock edge e, with no packet outstanding. req_o toggles after edge e+1. pkt_o then carries sp_addr_i in bits [113:102], mask bit k (mask in bits [87:80]) and that pixel's data word in bits [k*10+9 : k*10].
- R3: The readout is sparse. A pixel whose mask bit is 0 has its data field at zero, and the mask holds only pixels with a hit.
- R4: Hits sampled on the same edge go out in one packet. Its 14-bit timestamp field (bits [101:88]) holds the ts_i value sampled with the first hit of that packet.
- R5: After a launch, req_o and pkt_o stay unchanged until an acknowledge toggle (ack_i differing from its value on the previous edge) has been sampled.
- R6: A pixel that holds a hit ignores further strobes, and keeps its data, until the acknowledge of the packet that carried it.
- R7: Hits sampled while a packet is outstanding wait. On the edge after the acknowledge toggle is sampled, they are launched as the next packet with the timestamp of the earliest of them.
- R8: An acknowledge toggle sampled while no packet is outstanding has no effect. It neither changes req_o or pkt_o nor acknowledges the next packet.
- R9: Mask bit index is row*2+col: pixel index k on hit_i and pix_data_i maps to mask bit k and data field k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sp_addr_i | input | 12 | Group address placed in every packet |
| ts_i | input | 14 | Free-running timestamp |
| hit_i | input | 8 | Per-pixel hit strobes, index row*2+col |
| pix_data_i | input | 80 | Per-pixel data words, 10 bits each |
| ack_i | input | 1 | Acknowledge, toggles once per accepted packet |
| req_o | output | 1 | Request, toggles once per launched packet |
| pkt_o | output | 114 | Packet: address, timestamp, mask, data fields |

## Verification
Two functions can fall in the same cycle. The first is the release of in-flight pixels on an acknowledge edge; the second is the capture of fresh hits on other pixels, together with the launch of a waiting packet. The bench drives strobes in the very cycle it toggles ack_i. It also drives them in the cycle that a launch consumes the held hits. It judges the next packet's mask and timestamp, checking that the new hits are neither lost nor merged into the packet already leaving. A behavioural model, driven by random hit patterns and random acknowledge delays that include stray toggles, is compared with the outputs on every clock.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int SP_COLS = 2;
  localparam int SP_ROWS = 4;

  typedef enum logic {LNK_IDLE = 1'b0, LNK_WAIT = 1'b1} lnk_state_e;

  function automatic int pix_idx(input int row, input int col);
    return row * SP_COLS + col;
  endfunction
endpackage

// File: rtl/sp_pixel_slot.sv
module sp_pixel_slot #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clr_i,
  output logic              held_o,
  output logic              take_o,
  output logic [DATA_W-1:0] data_o
);
  assign take_o = hit_i & ~held_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_o <= 1'b0;
      data_o <= '0;
    end else if (clr_i) begin
      held_o <= 1'b0;
    end else if (take_o) begin
      held_o <= 1'b1;
      data_o <= data_i;
    end
  end

  // R6: held word survives strobes until released
  a_r6_hold_until_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_o && !clr_i |=> held_o && $stable(data_o));
endmodule

// File: rtl/sp_ts_merge.sv
module sp_ts_merge #(
  parameter int TS_W = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            new_hit_i,
  input  logic            pend_empty_i,
  input  logic [TS_W-1:0] ts_i,
  output logic [TS_W-1:0] ts_o
);
  // first hit of a fresh batch opens the shared timestamp
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_o <= '0;
    else if (new_hit_i && pend_empty_i) ts_o <= ts_i;
  end

  a_r4_ts_only_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !new_hit_i |=> $stable(ts_o));
endmodule

// File: rtl/sp_link_tx.sv
module sp_link_tx
  import sp_pkg::*;
#(
  parameter int NPIX   = 8,
  parameter int DATA_W = 10,
  parameter int TS_W   = 14,
  parameter int ADDR_W = 12,
  localparam int PKT_W = ADDR_W + TS_W + NPIX + NPIX * DATA_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NPIX-1:0]        pending_i,
  input  logic [NPIX*DATA_W-1:0] data_i,
  input  logic [TS_W-1:0]        ts_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   ack_i,
  output logic                   launch_o,
  output logic [NPIX-1:0]        clr_o,
  output logic                   req_o,
  output logic [PKT_W-1:0]       pkt_o
);
  lnk_state_e            state_q;
  logic                  ack_q;
  logic                  ack_edge;
  logic                  done;
  logic [NPIX-1:0]       inflight_q;
  logic [NPIX*DATA_W-1:0] data_sel;

  assign ack_edge = ack_i ^ ack_q;
  assign launch_o = (state_q == LNK_IDLE) && (|pending_i);
  assign done     = (state_q == LNK_WAIT) && ack_edge;
  assign clr_o    = done ? inflight_q : '0;

  for (genvar k = 0; k < NPIX; k++) begin : g_sel
    assign data_sel[k*DATA_W +: DATA_W] = pending_i[k] ? data_i[k*DATA_W +: DATA_W] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= LNK_IDLE;
      ack_q      <= 1'b0;
      inflight_q <= '0;
      req_o      <= 1'b0;
      pkt_o      <= '0;
    end else begin
      ack_q <= ack_i;
      if (launch_o) begin
        state_q    <= LNK_WAIT;
        inflight_q <= pending_i;
        req_o      <= ~req_o;
        pkt_o      <= {addr_i, ts_i, pending_i, data_sel};
      end else if (done) begin
        state_q    <= LNK_IDLE;
        inflight_q <= '0;
      end
    end
  end

  a_r5_hold_while_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LNK_WAIT) && !ack_edge |=> $stable(req_o) && $stable(pkt_o));
  a_r8_idle_ack_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LNK_IDLE) && ack_edge && !(|pending_i) |=> $stable(req_o) && (state_q == LNK_IDLE));
  a_r5_nonempty_packet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> (pkt_o[NPIX*DATA_W +: NPIX] != '0));
endmodule

// File: rtl/sp_readout.sv
module sp_readout
  import sp_pkg::*;
#(
  parameter int COLS   = SP_COLS,
  parameter int ROWS   = SP_ROWS,
  parameter int DATA_W = 10,
  parameter int TS_W   = 14,
  parameter int ADDR_W = 12,
  localparam int NPIX  = COLS * ROWS,
  localparam int PKT_W = ADDR_W + TS_W + NPIX + NPIX * DATA_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      sp_addr_i,
  input  logic [TS_W-1:0]        ts_i,
  input  logic [NPIX-1:0]        hit_i,
  input  logic [NPIX*DATA_W-1:0] pix_data_i,
  input  logic                   ack_i,
  output logic                   req_o,
  output logic [PKT_W-1:0]       pkt_o
);
  logic [NPIX-1:0]        held;
  logic [NPIX-1:0]        take;
  logic [NPIX-1:0]        clr;
  logic [NPIX-1:0]        inflight_q;
  logic [NPIX-1:0]        pending;
  logic [NPIX*DATA_W-1:0] slot_data;
  logic [TS_W-1:0]        grp_ts;
  logic                   launch;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int K = r * COLS + c;
      sp_pixel_slot #(.DATA_W(DATA_W)) u_slot (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hit_i  (hit_i[K]),
        .data_i (pix_data_i[K*DATA_W +: DATA_W]),
        .clr_i  (clr[K]),
        .held_o (held[K]),
        .take_o (take[K]),
        .data_o (slot_data[K*DATA_W +: DATA_W])
      );
    end
  end

  // pixels already on the bus are not pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     inflight_q <= '0;
    else if (launch) inflight_q <= pending;
    else if (|clr)   inflight_q <= '0;
  end
  assign pending = held & ~inflight_q;

  sp_ts_merge #(.TS_W(TS_W)) u_ts (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .new_hit_i    (|take),
    .pend_empty_i (launch || !(|pending)),
    .ts_i         (ts_i),
    .ts_o         (grp_ts)
  );

  sp_link_tx #(
    .NPIX(NPIX), .DATA_W(DATA_W), .TS_W(TS_W), .ADDR_W(ADDR_W)
  ) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pending_i (pending),
    .data_i    (slot_data),
    .ts_i      (grp_ts),
    .addr_i    (sp_addr_i),
    .ack_i     (ack_i),
    .launch_o  (launch),
    .clr_o     (clr),
    .req_o     (req_o),
    .pkt_o     (pkt_o)
  );

  // R3: unmasked data fields stay zero
  for (genvar k = 0; k < NPIX; k++) begin : g_chk
    a_r3_sparse_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pkt_o[NPIX*DATA_W + k] |-> (pkt_o[k*DATA_W +: DATA_W] == '0));
  end
  // R6: release only pixels that were on the bus
  a_r6_clear_inflight_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr & ~inflight_q) == '0);
  a_r1_reset_quiet: assert property (@(posedge clk_i) !rst_ni |-> !req_o && (pkt_o == '0));
endmodule

// File: tb/sp_readout_tb_top.sv
module sp_readout_tb_top;
  localparam int NP = 8, DW = 10, TW = 14, AW = 12;
  localparam int PW = AW + TW + NP + NP * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = 12'hA3C;
  logic [TW-1:0] ts = '0;
  logic [NP-1:0] hit = '0;
  logic [NP*DW-1:0] pdat = '0;
  logic          ack = 1'b0;
  logic          req;
  logic [PW-1:0] pkt;

  always #5 clk = ~clk;

  sp_readout dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sp_addr_i(addr), .ts_i(ts), .hit_i(hit),
    .pix_data_i(pdat), .ack_i(ack), .req_o(req), .pkt_o(pkt)
  );

  int n_vec = 0, n_bad = 0, tsc = 0;
  bit finished = 0;

  // behavioural reference
  bit          m_held[NP];
  bit          m_infl[NP];
  int          m_data[NP];
  bit          m_busy = 0, m_req = 0, m_ackq = 0;
  int          m_ts = 0;
  logic [PW-1:0] m_pkt = '0;

  always @(posedge clk) if (rst_n) begin
    bit edge_seen, any_pend, any_new, launch;
    edge_seen = (ack != m_ackq);
    any_pend = 0; any_new = 0;
    foreach (m_held[k]) begin
      if (m_held[k] && !m_infl[k]) any_pend = 1;
      if (hit[k] && !m_held[k]) any_new = 1;
    end
    launch = !m_busy && any_pend;
    if (any_new && (launch || !any_pend)) m_ts = ts;
    if (launch) begin
      m_pkt = '0;
      m_pkt[PW-1 -: AW] = addr;
      m_pkt[PW-AW-1 -: TW] = TW'(m_ts_prev);
      foreach (m_held[k]) if (m_held[k] && !m_infl[k]) begin
        m_pkt[NP*DW + k] = 1'b1;
        m_pkt[k*DW +: DW] = DW'(m_data[k]);
        m_infl[k] = 1;
      end
      m_req = !m_req; m_busy = 1;
    end else if (m_busy && edge_seen) begin
      foreach (m_held[k]) if (m_infl[k]) begin m_held[k] = 0; m_infl[k] = 0; end
      m_busy = 0;
    end
    foreach (m_held[k]) if (hit[k] && !m_held[k] && !(m_infl_clr_guard(k))) begin
      m_held[k] = 1; m_data[k] = int'(pdat[k*DW +: DW]);
    end
    m_ackq = ack;
    m_ts_prev = m_ts;
  end

  int m_ts_prev = 0;
  bit m_was_held[NP];
  // pixels released on this edge ignore a strobe on the same edge
  always @(negedge clk) foreach (m_held[k]) m_was_held[k] = m_held[k];
  function automatic bit m_infl_clr_guard(int k);
    return m_was_held[k];
  endfunction

  task automatic chk(bit ok, string rq, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pd(int k, int t);
    return DW'(t * 16 + k * 3 + 5);
  endfunction
  function automatic logic [7:0] f_mask(); return pkt[NP*DW +: NP]; endfunction
  function automatic logic [TW-1:0] f_ts(); return pkt[PW-AW-1 -: TW]; endfunction
  function automatic logic [DW-1:0] f_dat(int k); return pkt[k*DW +: DW]; endfunction

  // compare at negedge, then drive the next cycle
  task automatic step(logic [NP-1:0] h, bit flip = 0);
    @(negedge clk);
    if (rst_n) begin
      chk(req == m_req, "R5 req", PW'(req), PW'(m_req));
      chk(pkt == m_pkt, "R2 R3 R4 pkt", pkt, m_pkt);
    end
    hit = h;
    ts = TW'(tsc);
    for (int k = 0; k < NP; k++) pdat[k*DW +: DW] = pd(k, tsc);
    if (flip) ack = ~ack;
    tsc++;
  endtask

  int t1, t2, t3;
  bit last_req = 0;

  initial begin
    repeat (3) @(negedge clk);
    chk(req == 1'b0 && pkt == '0, "R1", pkt, '0);
    rst_n = 1'b1;
    step(0); step(0);
    // single hit, pixel row 2 col 1 -> index 5 (R9)
    t1 = tsc; step(8'h20);
    step(0); chk(req == 1'b0, "R2 latency", PW'(req), 0);
    step(0);
    chk(req == 1'b1, "R2 launch", PW'(req), 1);
    chk(f_mask() == 8'h20, "R9 mask", PW'(f_mask()), PW'(8'h20));
    chk(f_dat(5) == pd(5, t1), "R2 data", PW'(f_dat(5)), PW'(pd(5, t1)));
    chk(pkt[PW-1 -: AW] == addr, "R2 addr", PW'(pkt[PW-1 -: AW]), PW'(addr));
    chk(f_dat(0) == '0 && f_dat(4) == '0, "R3", PW'(f_dat(4)), 0);
    step(0); step(0); step(0);
    chk(req == 1'b1 && f_mask() == 8'h20, "R5 hold", PW'(f_mask()), PW'(8'h20));
    step(0, 1); step(0); step(0);
    chk(req == 1'b1, "R8 no relaunch", PW'(req), 1);
    // merged hits
    t2 = tsc; step(8'hA5);
    step(0); step(0);
    chk(req == 1'b0 && f_mask() == 8'hA5, "R4 merge", PW'(f_mask()), PW'(8'hA5));
    chk(f_ts() == TW'(t2), "R4 ts", PW'(f_ts()), PW'(t2));
    // hits during transfer, re-hit of in-flight pixel 0
    step(8'h01); t3 = tsc; step(8'h02); step(8'h40); step(0);
    chk(req == 1'b0 && f_mask() == 8'hA5, "R5 wait", PW'(f_mask()), PW'(8'hA5));
    step(0, 1); step(0);
    chk(req == 1'b0, "R7 not before release", PW'(req), 0);
    step(0);
    chk(req == 1'b1 && f_mask() == 8'h42, "R7 next pkt", PW'(f_mask()), PW'(8'h42));
    chk(f_ts() == TW'(t3), "R7 ts", PW'(f_ts()), PW'(t3));
    chk(f_mask()[0] == 1'b0, "R6 ignored rehit", PW'(f_mask()), PW'(8'h42));
    step(0, 1); step(0); step(0);
    // stray acknowledge while idle
    step(0, 1); step(0); step(0);
    chk(req == 1'b1 && f_mask() == 8'h42, "R8 stray ack", PW'(f_mask()), PW'(8'h42));
    step(8'h80); step(0); step(0);
    chk(req == 1'b0 && f_mask() == 8'h80, "R8 launch", PW'(f_mask()), PW'(8'h80));
    step(8'h01); step(0); step(0); step(0);
    chk(req == 1'b0 && f_mask() == 8'h80, "R8 not pre-acked", PW'(f_mask()), PW'(8'h80));
    // ack and fresh hit in the same cycle
    step(8'h08, 1); step(0); step(0);
    chk(req == 1'b1 && f_mask() == 8'h09, "R7 ack+hit", PW'(f_mask()), PW'(8'h09));
    step(0, 1); step(0); step(0);
    last_req = req;
    // random traffic with a behaving end-of-column unit
    for (int i = 0; i < 4000; i++) begin
      logic [NP-1:0] h;
      bit f;
      h = '0;
      for (int k = 0; k < NP; k++) if ($urandom_range(0, 9) == 0) h[k] = 1'b1;
      f = 0;
      if (req != last_req) begin
        if ($urandom_range(0, 3) == 0) begin f = 1; last_req = req; end
      end else if (!m_busy && $urandom_range(0, 40) == 0) f = 1;
      step(h, f);
    end
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule